// File: doc/BRIEF.md
# Control Word Loader for a Numerically Controlled Oscillator

This block sits on the host side of a frequency synthesizer. It builds a 40-bit control word made of a 32-bit tuning word, a 5-bit phase offset, a power-down bit and a 2-bit control code. The word goes into a holding register, either as five byte writes on an 8-bit bus or as a 40-bit bit-serial stream on bus bit 7. An update strobe then commits the holding register to the active outputs that drive the oscillator core.

Word-load and update events arrive as single-cycle pulses that are synchronous to `clk`. The block starts in byte mode. One specific control code, committed from byte mode, switches it into bit-serial mode. Any other nonzero control code is refused and raises a sticky error flag. A synchronous master clear resets the active state but keeps the holding register. An asynchronous `rst_n` clears everything.

Top module: `ctl_word_loader`

## Requirements
- R1: In byte mode each `wclk_evt` stores `bus_data` into the byte slot chosen by an internal pointer and advances the pointer. After five stored bytes, further `wclk_evt` pulses leave the holding register unchanged until the pointer is restarted.
- R2: An `upd_evt` pulse returns the pointer to slot 0 and, for control code 00, copies the holding register to `tune_word`, `phase_word` and `pwr_down`. The new values are visible in the cycle after the pulse.
- R3: `tune_word`, `phase_word` and `pwr_down` change only on an accepted update or on a master clear. Word-load pulses alone never change them.
- R4: Byte layout in byte mode. Slot 0 carries the phase in bits 7..3 (phase bit 4 in bus bit 7), power-down in bit 2 and the control code in bits 1..0. Slots 1 to 4 carry the tuning word, most significant byte first.
- R5: In serial mode each `wclk_evt` shifts in `bus_data[7]`. Over 40 shifts the bits are taken in this order: tuning bits 0 to 31, control bit 0, control bit 1, power-down, then phase bits 0 to 4.
- R6: An update in byte mode whose slot-0 low three bits are 011 (control code 11, power-down 0) sets `serial_mode`. It leaves the active words unchanged and does not raise `rsvd_err`.
- R7: Any other update with a nonzero control code (01, 10, or 11 outside the R6 case, including every nonzero code in serial mode) sets `rsvd_err` and leaves the active words unchanged. `rsvd_err` stays set until a reset.
- R8: `master_clr` restarts the pointer and clears `tune_word`, `phase_word`, `pwr_down`, `serial_mode` and `rsvd_err`. It leaves the holding register unchanged, so a later update with no writes commits the earlier contents.
- R9: The committed power-down bit drives `pwr_down`. Committing a word with that bit 0 clears it again, in either loading mode.
- R10: An update after fewer than five byte writes commits all 40 bits. Slots that were not written keep their earlier holding-register values.
- R11: Priority order is `master_clr`, then `upd_evt`, then `wclk_evt`. A word-load pulse in the same cycle as either of the others is discarded.
- R12: `rst_n` low clears the holding register, the pointer and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| master_clr | input | 1 | Synchronous master clear, holding register kept |
| wclk_evt | input | 1 | Word-load event pulse |
| upd_evt | input | 1 | Update (commit) event pulse |
| bus_data | input | 8 | Byte bus; bit 7 is the serial data input |
| tune_word | output | 32 | Active tuning word |
| phase_word | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| serial_mode | output | 1 | Bit-serial loading selected |
| rsvd_err | output | 1 | Sticky flag for a refused reserved control code |

## Verification
The assertions assume that the event inputs are clean single-cycle pulses sampled on `clk`, and that the block does not have to resolve coincident events beyond the fixed priority of R11. The stimulus drives each event for exactly one cycle between falling edges. It overlaps events only in the dedicated priority cases. The sweeps cover every phase value, every partial-write count, every reserved control code and full serial frames, and the bench derives the expected outputs from its own field-level model of the holding register.

// File: rtl/ctl_loader_pkg.sv
package ctl_loader_pkg;

  localparam int unsigned CTRL_W = 2;
  localparam logic [CTRL_W-1:0] SERIAL_KEY = 2'b11;

  typedef enum logic [1:0] {
    CMT_NONE   = 2'd0,
    CMT_APPLY  = 2'd1,
    CMT_SERIAL = 2'd2,
    CMT_REJECT = 2'd3
  } commit_kind_e;

endpackage

// File: rtl/ctl_byte_ptr.sv
module ctl_byte_ptr #(
  parameter int unsigned NUM_BYTES = 5,
  parameter int unsigned PTR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic             full
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BYTES);

  assign full = (ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (restart) begin
      ptr <= '0;
    end else if (step && !full) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/ctl_hold_reg.sv
module ctl_hold_reg #(
  parameter int unsigned FRAME_W   = 40,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 5,
  parameter int unsigned PTR_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_wr,
  input  logic               ser_shift,
  input  logic [PTR_W-1:0]   ptr,
  input  logic [BYTE_W-1:0]  din,
  output logic [FRAME_W-1:0] hold
);

  // Slot k occupies the bits just below slot k-1, starting at the top.
  function automatic int unsigned slot_lsb(input int unsigned k);
    return FRAME_W - (k + 1) * BYTE_W;
  endfunction

  logic [FRAME_W-1:0] shifted;
  logic [FRAME_W-1:0] hold_nxt;

  assign shifted = {din[BYTE_W-1], hold[FRAME_W-1:1]};

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
    logic slot_sel;
    assign slot_sel = par_wr && (ptr == PTR_W'(k));
    assign hold_nxt[slot_lsb(k) +: BYTE_W] =
      ser_shift ? shifted[slot_lsb(k) +: BYTE_W] :
      slot_sel  ? din :
                  hold[slot_lsb(k) +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else begin
      hold <= hold_nxt;
    end
  end

endmodule

// File: rtl/ctl_commit.sv
module ctl_commit
  import ctl_loader_pkg::*;
#(
  parameter int unsigned TUNE_W  = 32,
  parameter int unsigned PHASE_W = 5,
  parameter int unsigned FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               commit,
  input  logic [FRAME_W-1:0] hold,
  output logic [TUNE_W-1:0]  tune_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic               pwr_down,
  output logic               serial_mode,
  output logic               rsvd_err,
  output commit_kind_e       kind
);

  function automatic logic [TUNE_W-1:0] f_tune(input logic [FRAME_W-1:0] f);
    return f[TUNE_W-1:0];
  endfunction

  function automatic logic [CTRL_W-1:0] f_ctrl(input logic [FRAME_W-1:0] f);
    return f[TUNE_W +: CTRL_W];
  endfunction

  function automatic logic f_pd(input logic [FRAME_W-1:0] f);
    return f[TUNE_W + CTRL_W];
  endfunction

  function automatic logic [PHASE_W-1:0] f_phase(input logic [FRAME_W-1:0] f);
    return f[TUNE_W + CTRL_W + 1 +: PHASE_W];
  endfunction

  function automatic commit_kind_e classify(input logic [FRAME_W-1:0] f,
                                            input logic in_serial);
    if (f_ctrl(f) == '0) begin
      return CMT_APPLY;
    end else if (!in_serial && f_ctrl(f) == SERIAL_KEY && !f_pd(f)) begin
      return CMT_SERIAL;
    end else begin
      return CMT_REJECT;
    end
  endfunction

  assign kind = commit ? classify(hold, serial_mode) : CMT_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_word   <= '0;
      phase_word  <= '0;
      pwr_down    <= 1'b0;
      serial_mode <= 1'b0;
      rsvd_err    <= 1'b0;
    end else if (clr) begin
      tune_word   <= '0;
      phase_word  <= '0;
      pwr_down    <= 1'b0;
      serial_mode <= 1'b0;
      rsvd_err    <= 1'b0;
    end else begin
      unique case (kind)
        CMT_APPLY: begin
          tune_word  <= f_tune(hold);
          phase_word <= f_phase(hold);
          pwr_down   <= f_pd(hold);
        end
        CMT_SERIAL: serial_mode <= 1'b1;
        CMT_REJECT: rsvd_err    <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctl_word_loader.sv
module ctl_word_loader
  import ctl_loader_pkg::*;
#(
  parameter int unsigned TUNE_W  = 32,
  parameter int unsigned PHASE_W = 5,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_clr,
  input  logic               wclk_evt,
  input  logic               upd_evt,
  input  logic [BYTE_W-1:0]  bus_data,
  output logic [TUNE_W-1:0]  tune_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic               pwr_down,
  output logic               serial_mode,
  output logic               rsvd_err
);

  localparam int unsigned FRAME_W   = TUNE_W + PHASE_W + 1 + CTRL_W;
  localparam int unsigned NUM_BYTES = FRAME_W / BYTE_W;
  localparam int unsigned PTR_W     = $clog2(NUM_BYTES + 1);

  // Named internal events, also observed by the bound checker.
  logic               wr_accept;
  logic               par_wr;
  logic               ser_shift;
  logic               commit;
  logic               ptr_restart;
  logic               ptr_full;
  logic [PTR_W-1:0]   ptr;
  logic [FRAME_W-1:0] hold;
  commit_kind_e       kind;
  logic               commit_reject;

  assign commit      = upd_evt && !master_clr;
  assign wr_accept   = wclk_evt && !upd_evt && !master_clr;
  assign par_wr      = wr_accept && !serial_mode && !ptr_full;
  assign ser_shift   = wr_accept && serial_mode;
  assign ptr_restart = master_clr || upd_evt;

  ctl_byte_ptr #(
    .NUM_BYTES (NUM_BYTES),
    .PTR_W     (PTR_W)
  ) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ptr_restart),
    .step    (par_wr),
    .ptr     (ptr),
    .full    (ptr_full)
  );

  ctl_hold_reg #(
    .FRAME_W   (FRAME_W),
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .PTR_W     (PTR_W)
  ) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_wr    (par_wr),
    .ser_shift (ser_shift),
    .ptr       (ptr),
    .din       (bus_data),
    .hold      (hold)
  );

  ctl_commit #(
    .TUNE_W  (TUNE_W),
    .PHASE_W (PHASE_W),
    .FRAME_W (FRAME_W)
  ) commit_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (master_clr),
    .commit      (commit),
    .hold        (hold),
    .tune_word   (tune_word),
    .phase_word  (phase_word),
    .pwr_down    (pwr_down),
    .serial_mode (serial_mode),
    .rsvd_err    (rsvd_err),
    .kind        (kind)
  );

  assign commit_reject = (kind == CMT_REJECT);

endmodule

// File: rtl/ctl_word_loader_chk.sv
module ctl_word_loader_chk #(
  parameter int unsigned TUNE_W    = 32,
  parameter int unsigned PHASE_W   = 5,
  parameter int unsigned FRAME_W   = 40,
  parameter int unsigned NUM_BYTES = 5,
  parameter int unsigned PTR_W     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               master_clr,
  input logic               wclk_evt,
  input logic               upd_evt,
  input logic               serial_mode,
  input logic               rsvd_err,
  input logic               pwr_down,
  input logic [TUNE_W-1:0]  tune_word,
  input logic [PHASE_W-1:0] phase_word,
  input logic [PTR_W-1:0]   ptr,
  input logic [FRAME_W-1:0] hold,
  input logic               commit_reject
);

  p_ptr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(NUM_BYTES));

  p_full_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_evt && !serial_mode && ptr == PTR_W'(NUM_BYTES)) |=> $stable(hold));

  p_upd_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (ptr == '0));

  p_active_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !master_clr) |=>
      ($stable(tune_word) && $stable(phase_word) && $stable(pwr_down)));

  p_serial_by_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serial_mode) |-> $past(upd_evt));

  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_reject |=>
      ($stable(tune_word) && $stable(phase_word) && $stable(pwr_down) && rsvd_err));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_err && !master_clr) |=> rsvd_err);

  p_clr_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> (tune_word == '0 && phase_word == '0 && !pwr_down &&
                    !serial_mode && !rsvd_err && ptr == '0));

  p_clr_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> $stable(hold));

  p_coincide_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_evt && (upd_evt || master_clr)) |=> $stable(hold));

endmodule

bind ctl_word_loader ctl_word_loader_chk #(
  .TUNE_W    (TUNE_W),
  .PHASE_W   (PHASE_W),
  .FRAME_W   (FRAME_W),
  .NUM_BYTES (NUM_BYTES),
  .PTR_W     (PTR_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_clr    (master_clr),
  .wclk_evt      (wclk_evt),
  .upd_evt       (upd_evt),
  .serial_mode   (serial_mode),
  .rsvd_err      (rsvd_err),
  .pwr_down      (pwr_down),
  .tune_word     (tune_word),
  .phase_word    (phase_word),
  .ptr           (ptr),
  .hold          (hold),
  .commit_reject (commit_reject)
);

// File: tb/ctl_word_loader_tb_top.sv
`timescale 1ns/1ps
module ctl_word_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_clr = 1'b0;
  logic        wclk_evt = 1'b0;
  logic        upd_evt = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [31:0] tune_word;
  logic [4:0]  phase_word;
  logic        pwr_down;
  logic        serial_mode;
  logic        rsvd_err;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ctl_word_loader dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_clr  (master_clr),
    .wclk_evt    (wclk_evt),
    .upd_evt     (upd_evt),
    .bus_data    (bus_data),
    .tune_word   (tune_word),
    .phase_word  (phase_word),
    .pwr_down    (pwr_down),
    .serial_mode (serial_mode),
    .rsvd_err    (rsvd_err)
  );

  // Field-level model of the holding register and active state.
  logic [31:0] h_tune = '0;
  logic [4:0]  h_ph = '0;
  logic        h_pd = 1'b0;
  logic [1:0]  h_ctl = '0;
  int          h_ptr = 0;
  logic [31:0] a_tune = '0;
  logic [4:0]  a_ph = '0;
  logic        a_pd = 1'b0;
  logic        a_ser = 1'b0;
  logic        a_err = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check_out(input string req);
    logic [39:0] got, exp;
    got = {tune_word, phase_word, pwr_down, serial_mode, rsvd_err};
    exp = {a_tune, a_ph, a_pd, a_ser, a_err};
    n_checks = n_checks + 1;
    if (got !== exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Bit i of the serial frame, taken from the model fields.
  function automatic logic ser_bit(input int i);
    if (i < 32) return h_tune[i];
    if (i == 32) return h_ctl[0];
    if (i == 33) return h_ctl[1];
    if (i == 34) return h_pd;
    return h_ph[i-35];
  endfunction

  task automatic model_shift(input logic b);
    logic [39:0] v;
    for (int i = 0; i < 40; i++) v[i] = ser_bit(i);
    v = {b, v[39:1]};
    for (int i = 0; i < 32; i++) h_tune[i] = v[i];
    h_ctl = {v[33], v[32]};
    h_pd = v[34];
    for (int i = 0; i < 5; i++) h_ph[i] = v[35+i];
  endtask

  task automatic model_byte(input logic [7:0] d);
    if (h_ptr == 0) begin
      h_ph = d[7:3]; h_pd = d[2]; h_ctl = d[1:0];
    end else if (h_ptr < 5) begin
      h_tune[(4-h_ptr)*8 +: 8] = d;
    end
    if (h_ptr < 5) h_ptr = h_ptr + 1;
  endtask

  task automatic do_write(input logic [7:0] d, input string req);
    @(negedge clk);
    bus_data = d; wclk_evt = 1'b1;
    @(negedge clk);
    wclk_evt = 1'b0;
    if (a_ser) model_shift(d[7]); else model_byte(d);
    check_out(req);
  endtask

  task automatic model_commit();
    h_ptr = 0;
    if (h_ctl == 2'b00) begin
      a_tune = h_tune; a_ph = h_ph; a_pd = h_pd;
    end else if (!a_ser && h_ctl == 2'b11 && !h_pd) begin
      a_ser = 1'b1;
    end else begin
      a_err = 1'b1;
    end
  endtask

  task automatic do_update(input string req);
    @(negedge clk);
    upd_evt = 1'b1;
    @(negedge clk);
    upd_evt = 1'b0;
    model_commit();
    check_out(req);
  endtask

  task automatic do_clr(input string req);
    @(negedge clk);
    master_clr = 1'b1;
    @(negedge clk);
    master_clr = 1'b0;
    h_ptr = 0; a_tune = '0; a_ph = '0; a_pd = 1'b0; a_ser = 1'b0; a_err = 1'b0;
    check_out(req);
  endtask

  task automatic write_word(input logic [31:0] t, input logic [4:0] p,
                            input logic pd, input logic [1:0] c, input string req);
    do_write({p, pd, c}, req);
    for (int k = 3; k >= 0; k--) do_write(t[k*8 +: 8], req);
  endtask

  task automatic serial_word(input logic [31:0] t, input logic [4:0] p,
                             input logic pd, input logic [1:0] c, input string req);
    logic [39:0] f;
    f = {p, pd, c, t};
    for (int i = 0; i < 40; i++) do_write({f[i], 7'h55}, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R12 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R9: sweep every phase value with varied tuning words and power-down.
    for (int ph = 0; ph < 32; ph++) begin
      write_word(32'h9E37_79B9 * (ph + 1), 5'(ph), ph[0], 2'b00, "R1 R3 byte load");
      do_update("R4 R9 R2 byte commit");
    end
    write_word(32'h1234_5678, 5'd9, 1'b0, 2'b00, "R3");
    do_update("R9 power back up");

    // R1: writes past the fifth are ignored.
    write_word(32'hCAFE_F00D, 5'd17, 1'b0, 2'b00, "R1");
    for (int k = 0; k < 3; k++) do_write(8'hFF, "R1 extra write");
    do_update("R1 extra writes ignored");

    // R10: partial loads of 0..4 bytes.
    for (int n = 0; n < 5; n++) begin
      for (int k = 0; k < n; k++) do_write(8'(8'h11 * (n + k + 1)) & 8'hF8, "R10 partial write");
      do_update("R10 partial commit");
    end

    // R11: write coinciding with update is dropped; pointer restarts.
    do_write(8'h00, "R11 setup");
    @(negedge clk);
    bus_data = 8'hA5; wclk_evt = 1'b1; upd_evt = 1'b1;
    @(negedge clk);
    wclk_evt = 1'b0; upd_evt = 1'b0;
    model_commit();
    check_out("R11 write with update dropped");
    do_write(8'hB0, "R11 slot0 after restart");
    do_update("R11 pointer restarted");

    // R11: write coinciding with master clear is dropped.
    write_word(32'h0F0F_0F0F, 5'd3, 1'b0, 2'b00, "R11 setup");
    @(negedge clk);
    bus_data = 8'h77; wclk_evt = 1'b1; master_clr = 1'b1;
    @(negedge clk);
    wclk_evt = 1'b0; master_clr = 1'b0;
    h_ptr = 0; a_tune = '0; a_ph = '0; a_pd = 1'b0; a_ser = 1'b0; a_err = 1'b0;
    check_out("R8 R11 clear with write");
    do_update("R8 R11 holding kept after clear");

    // R7: reserved codes in byte mode.
    for (int c = 1; c < 4; c++) begin
      write_word(32'hDEAD_0000 + 32'(c), 5'd30, (c == 3), 2'(c), "R7 setup");
      do_update("R7 reserved code refused");
      write_word(32'h0000_0100 * 32'(c), 5'd5, 1'b0, 2'b00, "R7 setup");
      do_update("R7 flag sticky after valid commit");
      do_clr("R8 clear drops error");
    end

    // R6: enter serial mode.
    write_word(32'h2222_3333, 5'd12, 1'b0, 2'b00, "R6 setup");
    do_update("R6 setup commit");
    do_write(8'b0000_0011, "R6 key byte");
    do_update("R6 serial entry");

    // R5 / R9: serial frames.
    serial_word(32'h8000_0001, 5'b10001, 1'b0, 2'b00, "R5 shift");
    do_update("R5 serial frame order");
    serial_word(32'h0123_4567, 5'd22, 1'b1, 2'b00, "R5 shift");
    do_update("R9 serial power-down");
    serial_word(32'hFEDC_BA98, 5'd7, 1'b0, 2'b00, "R5 shift");
    do_update("R9 serial power-up");
    serial_word(32'h5555_AAAA, 5'd1, 1'b0, 2'b11, "R5 shift");
    do_update("R7 serial reserved code");
    do_clr("R8 clear leaves serial mode");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule